// File: doc/BRIEF.md
# Root Port Control and Status Register

This block is the single control and status word of one downstream root port of a host controller. It holds three states that the port hardware drives: device present, port enabled and overcurrent. Each has a sticky change flag that latches when its state toggles. Software acknowledges a flag by writing 1 to it. The same word carries the plain software controls for resume, suspend, port reset, power and test selection. It also reports the live line levels and the speed of the attached device. While any change flag is set, a port-change interrupt stays asserted so that the core can raise its port status bit.

The enabled bit comes from a three-state machine. `PS_DISABLED` moves to `PS_RESETTING` when software sets the reset control. `PS_RESETTING` waits for software to clear that control. It then goes to `PS_ENABLED` if a device is present, and back to `PS_DISABLED` otherwise. `PS_ENABLED` moves to `PS_RESETTING` when the reset control is set again. It moves to `PS_DISABLED` when the device disconnects, when software writes 1 to the enabled bit, or when the port hardware reports a fault. Port reset timing itself is left to software.

Top module: `root_port_csr`

## Requirements
- R1: After reset, every bit of `reg_rdata` reads 0 and `port_irq` is low.
- R2: The hardware-only fields follow their inputs one clock later: connected at bit 0 from `hw_connect`, overcurrent at bit 4 from `hw_overcurrent`, line levels at bits 11:10 from `hw_line`. A software write to any of these bits has no effect.
- R3: Connect-changed (bit 1), enable-changed (bit 3) and overcurrent-changed (bit 5) each become 1 on the clock edge where the value of their companion bit (0, 2 and 4) changes.
- R4: Writing 1 to a change flag clears it, and writing 0 leaves it alone. If hardware sets the flag in the same cycle as the clearing write, the flag stays 1.
- R5: Writing 1 to the enabled bit (bit 2) while the port is enabled disables it on that edge and sets enable-changed. Writing 0, or writing 1 while the port is not enabled, leaves the enabled bit unchanged.
- R6: Setting the reset control (bit 8) moves the port into the resetting state with enabled at 0. Clearing the reset control enables the port on the next edge if `hw_connect` is 1, and leaves it disabled if `hw_connect` is 0.
- R7: While the port is enabled, `hw_connect` at 0 or `hw_fault` at 1 disables the port on the next edge and sets enable-changed.
- R8: `port_irq` is 1 exactly when at least one of bits 1, 3 and 5 reads 1.
- R9: Speed at bits 18:17 reports `hw_speed` (00 high, 01 full, 10 low) sampled one clock earlier, and reads 00 while the connected bit is 0.
- R10: Resume (bit 6), suspend (bit 7), reset (bit 8), power (bit 12) and test select (bits 16:13) take the written value on each write. Bit 9 and bits 31:19 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| hw_connect | input | 1 | Device present on the port |
| hw_overcurrent | input | 1 | Overcurrent detected on the port |
| hw_speed | input | 2 | Speed of the attached device |
| hw_line | input | 2 | Logic levels of the two data lines |
| hw_fault | input | 1 | Hardware-detected fault that drops port enable |
| port_irq | output | 1 | Port-change interrupt |

## Verification
The hardest case to reach from the ports is a hardware toggle and a software clear of the same flag on one clock edge, because the toggle must be timed against the write strobe. The bench puts the port in a state where the flag is already set. It then changes `hw_connect` and writes 1 to that flag in the same cycle, and checks that the flag survives. Enabling the port needs a full reset-control raise and release with a device present, so the directed sequences walk that path before each disabling cause. A long random phase, with reset control and connect toggling at low rates, then lands the port in every state of the machine.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        PS_DISABLED  = 2'd0,
        PS_RESETTING = 2'd1,
        PS_ENABLED   = 2'd2
    } port_state_e;

    // bit positions decoded by software
    localparam int POS_CONN     = 0;
    localparam int POS_CONN_CHG = 1;
    localparam int POS_EN       = 2;
    localparam int POS_EN_CHG   = 3;
    localparam int POS_OC       = 4;
    localparam int POS_OC_CHG   = 5;
    localparam int POS_RESUME   = 6;
    localparam int POS_SUSPEND  = 7;
    localparam int POS_RESET    = 8;
    localparam int POS_RSVD     = 9;
    localparam int POS_LINE     = 10;
    localparam int POS_POWER    = 12;
    localparam int POS_TEST     = 13;
    localparam int POS_SPEED    = 17;

    localparam int N_FLAGS = 3;

endpackage

// File: rtl/rpc_sticky_flag.sv
module rpc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // a hardware set outranks a software clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else begin
            flag_o <= set_i | (flag_o & ~clr_i);
        end
    end

endmodule

// File: rtl/rpc_enable_fsm.sv
module rpc_enable_fsm
    import rpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_ctl,
    input  logic dev_present,
    input  logic sw_disable,
    input  logic hw_fault,
    output logic enabled_o,
    output logic en_toggle_o
);

    port_state_e state_q;
    port_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        unique case (state_q)
            PS_DISABLED: begin
                if (reset_ctl) state_d = PS_RESETTING;
            end
            PS_RESETTING: begin
                if (!reset_ctl) state_d = dev_present ? PS_ENABLED : PS_DISABLED;
            end
            PS_ENABLED: begin
                if (reset_ctl) begin
                    state_d = PS_RESETTING;
                end else if (!dev_present || sw_disable || hw_fault) begin
                    state_d = PS_DISABLED;
                end
            end
            default: state_d = PS_DISABLED;
        endcase
        enabled_o   = (state_q == PS_ENABLED);
        en_toggle_o = (state_d == PS_ENABLED) != (state_q == PS_ENABLED);
    end

endmodule

// File: rtl/root_port_csr.sv
module root_port_csr
    import rpc_pkg::*;
#(
    parameter int CSR_W  = 32,
    parameter int LINE_W = 2,
    parameter int SPD_W  = 2,
    parameter int TEST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CSR_W-1:0]  reg_wdata,
    output logic [CSR_W-1:0]  reg_rdata,
    input  logic              hw_connect,
    input  logic              hw_overcurrent,
    input  logic [SPD_W-1:0]  hw_speed,
    input  logic [LINE_W-1:0] hw_line,
    input  logic              hw_fault,
    output logic              port_irq
);

    localparam int TEST_TOP = POS_TEST + TEST_W;

    logic              conn_q;
    logic              oc_q;
    logic [LINE_W-1:0] line_q;
    logic [SPD_W-1:0]  speed_q;
    logic              resume_q;
    logic              suspend_q;
    logic              reset_q;
    logic              power_q;
    logic [TEST_W-1:0] test_q;
    logic              enabled;
    logic              en_tgl;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_clr;
    logic [N_FLAGS-1:0] flag_q;

    // hardware-only status sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q  <= 1'b0;
            oc_q    <= 1'b0;
            line_q  <= '0;
            speed_q <= '0;
        end else begin
            conn_q  <= hw_connect;
            oc_q    <= hw_overcurrent;
            line_q  <= hw_line;
            speed_q <= hw_speed;
        end
    end

    // plain software controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q  <= 1'b0;
            suspend_q <= 1'b0;
            reset_q   <= 1'b0;
            power_q   <= 1'b0;
            test_q    <= '0;
        end else if (reg_wr) begin
            resume_q  <= reg_wdata[POS_RESUME];
            suspend_q <= reg_wdata[POS_SUSPEND];
            reset_q   <= reg_wdata[POS_RESET];
            power_q   <= reg_wdata[POS_POWER];
            test_q    <= reg_wdata[TEST_TOP-1:POS_TEST];
        end
    end

    rpc_enable_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_ctl   (reset_q),
        .dev_present (hw_connect),
        .sw_disable  (reg_wr & reg_wdata[POS_EN]),
        .hw_fault    (hw_fault),
        .enabled_o   (enabled),
        .en_toggle_o (en_tgl)
    );

    // flag index 0: connect, 1: enable, 2: overcurrent
    assign flag_set = {hw_overcurrent ^ oc_q, en_tgl, hw_connect ^ conn_q};
    assign flag_clr = {N_FLAGS{reg_wr}} &
                      {reg_wdata[POS_OC_CHG], reg_wdata[POS_EN_CHG], reg_wdata[POS_CONN_CHG]};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        rpc_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_q[g])
        );
    end

    assign port_irq = |flag_q;

    always_comb begin
        reg_rdata                            = '0;
        reg_rdata[POS_CONN]                  = conn_q;
        reg_rdata[POS_CONN_CHG]              = flag_q[0];
        reg_rdata[POS_EN]                    = enabled;
        reg_rdata[POS_EN_CHG]                = flag_q[1];
        reg_rdata[POS_OC]                    = oc_q;
        reg_rdata[POS_OC_CHG]                = flag_q[2];
        reg_rdata[POS_RESUME]                = resume_q;
        reg_rdata[POS_SUSPEND]               = suspend_q;
        reg_rdata[POS_RESET]                 = reset_q;
        reg_rdata[POS_LINE +: LINE_W]        = line_q;
        reg_rdata[POS_POWER]                 = power_q;
        reg_rdata[POS_TEST +: TEST_W]        = test_q;
        reg_rdata[POS_SPEED +: SPD_W]        = conn_q ? speed_q : '0;
    end

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[CSR_W-1:TEST_TOP],
                            reg_wdata[POS_LINE+LINE_W-1:POS_RSVD],
                            reg_wdata[POS_OC], reg_wdata[POS_CONN]};

endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
    parameter int CSR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [CSR_W-1:0] reg_wdata,
    input logic [CSR_W-1:0] reg_rdata,
    input logic             hw_connect,
    input logic             hw_fault,
    input logic             port_irq
);

    assert_conn_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hw_connect |=> reg_rdata[0]);
    assert_conn_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_connect |=> !reg_rdata[0]);

    assert_conn_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_connect != reg_rdata[0]) |=> reg_rdata[1]);

    assert_conn_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[1] && (hw_connect == reg_rdata[0])) |=> !reg_rdata[1]);

    assert_write_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && reg_wr && reg_wdata[2]) |=> (!reg_rdata[2] && reg_rdata[3]));

    assert_drop_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && (!hw_connect || hw_fault)) |=> (!reg_rdata[2] && reg_rdata[3]));

    assert_irq_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_irq == (reg_rdata[1] | reg_rdata[3] | reg_rdata[5]));

    assert_speed_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> (reg_rdata[18:17] == 2'b00));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[9] == 1'b0) && (reg_rdata[CSR_W-1:19] == '0));

    logic unused_chk;
    assign unused_chk = ^{reg_wdata[CSR_W-1:3], reg_wdata[0],
                          reg_rdata[16:10], reg_rdata[8:6], reg_rdata[4]};

endmodule

bind root_port_csr rpc_checker #(.CSR_W(CSR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .hw_connect (hw_connect),
    .hw_fault   (hw_fault),
    .port_irq   (port_irq)
);

// File: tb/sim_root_port_csr.sv
`timescale 1ns/1ps
module sim_root_port_csr;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_connect = 1'b0;
    logic        hw_overcurrent = 1'b0;
    logic [1:0]  hw_speed = '0;
    logic [1:0]  hw_line = '0;
    logic        hw_fault = 1'b0;
    logic        port_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    root_port_csr u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .hw_connect     (hw_connect),
        .hw_overcurrent (hw_overcurrent),
        .hw_speed       (hw_speed),
        .hw_line        (hw_line),
        .hw_fault       (hw_fault),
        .port_irq       (port_irq)
    );

    // behavioural reference model; state 0 disabled, 1 resetting, 2 enabled
    int       m_st;
    bit       m_conn, m_oc, m_cc, m_ec, m_occ;
    bit       m_res, m_sus, m_rst, m_pwr;
    bit [3:0] m_test;
    bit [1:0] m_line, m_spd;

    always @(posedge clk) begin
        int        nst;
        bit [31:0] w;
        if (!rst_n) begin
            m_st = 0; m_conn = 0; m_oc = 0; m_cc = 0; m_ec = 0; m_occ = 0;
            m_res = 0; m_sus = 0; m_rst = 0; m_pwr = 0; m_test = 0;
            m_line = 0; m_spd = 0;
        end else begin
            w   = reg_wr ? reg_wdata : 32'h0;
            nst = m_st;
            if (m_st == 0) begin
                if (m_rst) nst = 1;
            end else if (m_st == 1) begin
                if (!m_rst) nst = hw_connect ? 2 : 0;
            end else begin
                if (m_rst) nst = 1;
                else if (!hw_connect || hw_fault || w[2]) nst = 0;
            end
            m_cc  = (hw_connect != m_conn) || (m_cc && !w[1]);
            m_ec  = ((nst == 2) != (m_st == 2)) || (m_ec && !w[3]);
            m_occ = (hw_overcurrent != m_oc) || (m_occ && !w[5]);
            m_st   = nst;
            m_conn = hw_connect;
            m_oc   = hw_overcurrent;
            m_line = hw_line;
            m_spd  = hw_speed;
            if (reg_wr) begin
                m_res = w[6]; m_sus = w[7]; m_rst = w[8]; m_pwr = w[12];
                m_test = w[16:13];
            end
        end
    end

    function automatic logic [31:0] model_word();
        logic [31:0] e = '0;
        e[0] = m_conn; e[1] = m_cc; e[2] = (m_st == 2); e[3] = m_ec;
        e[4] = m_oc; e[5] = m_occ; e[6] = m_res; e[7] = m_sus; e[8] = m_rst;
        e[11:10] = m_line; e[12] = m_pwr; e[16:13] = m_test;
        e[18:17] = m_conn ? m_spd : 2'b00;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        logic [31:0] e;
        if (model_on) begin
            e = model_word();
            chk("R2 hw-only fields",     reg_rdata & 32'h0000_0C11, e & 32'h0000_0C11);
            chk("R3 R4 change flags",    reg_rdata & 32'h0000_002A, e & 32'h0000_002A);
            chk("R5 R6 R7 enabled bit",  reg_rdata & 32'h0000_0004, e & 32'h0000_0004);
            chk("R9 speed field",        reg_rdata & 32'h0006_0000, e & 32'h0006_0000);
            chk("R10 controls/reserved", reg_rdata & 32'hFFF9_F3C0, e & 32'hFFF9_F3C0);
            chk("R8 port_irq", {31'b0, port_irq}, {31'b0, (e[1] | e[3] | e[5])});
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        model_on = 1;
        cyc();
        chk("R1 reset word", reg_rdata, 32'h0);
        chk("R1 reset irq", {31'b0, port_irq}, 32'h0);

        wr(32'hFFFF_FFFF);
        chk("R10 R2 all-ones write", reg_rdata, 32'h0001_F1C0);
        cyc();
        wr(32'h0);
        cyc();
        chk("R6 release without device", reg_rdata, 32'h0);

        hw_connect = 1'b1; hw_speed = 2'b01; hw_line = 2'b10;
        cyc();
        chk("R3 R9 connect", reg_rdata, 32'h0002_0803);
        chk("R8 irq on connect", {31'b0, port_irq}, 32'h1);
        wr(32'h2);
        chk("R4 clear connect flag", reg_rdata, 32'h0002_0801);
        chk("R8 irq cleared", {31'b0, port_irq}, 32'h0);

        wr(32'h100); wr(32'h0); cyc();
        chk("R6 enable after reset release", reg_rdata, 32'h0002_080D);
        wr(32'h8);
        chk("R4 clear enable flag", reg_rdata, 32'h0002_0805);
        wr(32'h0);
        chk("R5 write 0 keeps enabled", reg_rdata, 32'h0002_0805);
        wr(32'h4);
        chk("R5 write 1 disables", reg_rdata, 32'h0002_0809);

        wr(32'h8); wr(32'h100); wr(32'h0); cyc();
        chk("R6 re-enable", reg_rdata, 32'h0002_080D);
        wr(32'h8);
        hw_connect = 1'b0;
        cyc();
        chk("R7 R9 disconnect disables", reg_rdata, 32'h0000_080A);

        hw_connect = 1'b1;
        wr(32'h2);
        chk("R4 set wins over clear", reg_rdata, 32'h0002_080B);
        wr(32'h2A);
        chk("R4 clear all flags", reg_rdata, 32'h0002_0801);

        hw_overcurrent = 1'b1;
        cyc();
        chk("R3 overcurrent rise", reg_rdata, 32'h0002_0831);
        hw_overcurrent = 1'b0;
        cyc();
        chk("R3 overcurrent fall", reg_rdata, 32'h0002_0821);
        wr(32'h20);

        wr(32'h100); wr(32'h0); cyc();
        wr(32'h8);
        chk("R6 enabled before fault", reg_rdata, 32'h0002_0805);
        hw_fault = 1'b1;
        cyc();
        hw_fault = 1'b0;
        chk("R7 fault disables", reg_rdata, 32'h0002_0809);
        wr(32'h4);
        chk("R5 write 1 while disabled ignored", reg_rdata, 32'h0002_0809);

        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) hw_connect = ~hw_connect;
            if ($urandom_range(15) == 0) hw_overcurrent = ~hw_overcurrent;
            hw_speed = 2'($urandom_range(2));
            hw_line  = 2'($urandom_range(3));
            hw_fault = ($urandom_range(31) == 0);
            reg_wr   = ($urandom_range(3) == 0);
            reg_wdata = $urandom;
            if ($urandom_range(1) == 0) reg_wdata[8] = 1'b0;
            cyc();
        end
        reg_wr = 1'b0;
        cyc();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1-chain hung actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule